// File: doc/BRIEF.md
# Relocatable Instruction Cache with Line Fill

This block holds instruction bytes for a coprocessor core in a 512-byte window. The window floats: its start is a 16-bit base address set by the core, and a fetch is cached when its distance above the base, taken modulo 2^16, is below 512. The window is split into 32 lines of 16 bytes, and each line has its own valid bit. If a fetch falls into an invalid line, the block reads the whole line from the memory bus and then serves the byte. A fetch outside the window is passed straight to the bus. A host can read and write the bytes through an indexed port. A host write to the last byte of a line marks that line valid, so software can preload code. A single clock-speed bit selects between a fast and a slow timing set.

Fetches use a valid/ready handshake. `fetch_ready` stays low for the whole latency and is high for exactly one cycle, when the handshake completes. The core side works like a one-byte pipeline. `fetch_rdata` always shows the byte that was loaded by the previous fetch. When a fetch completes, that register is loaded with the byte at the program counter, or at the program counter plus one.

The controller has four states. IDLE waits for a request. When `fetch_valid` is high it moves to PASS if the address is outside the window, to HIT if the line is valid, or to FILL otherwise; this step is the accept transition. HIT and PASS count down their latency and then make the done transition back to IDLE. FILL steps through the 16 line bytes. Each byte takes one full byte slot. After the last slot FILL makes the done transition back to IDLE.

Top module: `icache_reloc`

## Requirements
- R1: After reset, `fetch_ready`, `mem_req` and `fetch_rdata` are 0, every line is invalid, and every one of the 512 data bytes reads back as 0 through the host port.
- R2: The window offset is (effective address − `cfg_base`) mod 2^16. A fetch is cached only if the offset is below 512. The cached byte lives at index offset, and its line is offset bits [8:4].
- R3: On a miss, 16 bus reads are made in order. Read n (n = 0..15) is at {`cfg_bank`, L + n}, where L = (`cfg_base` + (offset & 0xFFF0)) & 0xFFF0. Read n is stored at index (offset & 0x1F0) + n, and the line is then valid.
- R4: A miss completes 16×5 cycles after acceptance when `cfg_fast`=1, and 16×6 cycles after acceptance when `cfg_fast`=0.
- R5: A hit completes 1 cycle (fast) or 2 cycles (slow) after acceptance and makes no bus request.
- R6: A fetch outside the window reads {`cfg_bank`, effective address} with `mem_req` high for 5 (fast) or 6 (slow) cycles. It completes at the end of those cycles and changes no cache byte or valid bit.
- R7: A one-cycle `flush` clears all 32 valid bits and keeps the data bytes.
- R8: A host access uses index (`host_addr` + `cfg_base`) mod 512. Read data appears on `host_rdata` one cycle after the request.
- R9: A host write whose index has low nibble 15 makes that line valid. A host write to any other index leaves the line's valid bit unchanged.
- R10: At completion `fetch_rdata` still shows the byte loaded by the previous fetch. After completion it shows the byte at the effective address, which is `fetch_pc` + 1 when `fetch_inc`=1 and `fetch_pc` otherwise.
- R11: `fetch_ready` is high for one cycle per request. During a request, `mem_addr` bits [23:4] do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_base | input | 16 | Start address of the cache window |
| cfg_bank | input | 8 | Bank placed above 16-bit addresses on the bus |
| cfg_fast | input | 1 | 1 selects the fast timing set |
| flush | input | 1 | Invalidates all lines |
| fetch_valid | input | 1 | Fetch request, held until ready |
| fetch_pc | input | 16 | Program counter |
| fetch_inc | input | 1 | Fetch at pc + 1 instead of pc |
| fetch_ready | output | 1 | Fetch completes this cycle |
| fetch_rdata | output | 8 | Prefetch register |
| mem_req | output | 1 | Bus read active |
| mem_addr | output | 24 | Bus read address |
| mem_rdata | input | 8 | Bus read data, valid in the same cycle |
| host_en | input | 1 | Host port access |
| host_we | input | 1 | Host access is a write |
| host_addr | input | 9 | Host byte index, relative to the base |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, one cycle later |

## Verification
A request is accepted on the first rising edge at which `fetch_valid` is seen in IDLE. `fetch_ready` is then due at the falling edge N cycles later: N is 1 or 2 for a hit, 5 or 6 for a pass-through, and 80 or 96 for a fill. The new prefetch byte is due after the next rising edge. The bench counts falling edges from acceptance to ready, logs `mem_addr` at each falling edge, and checks the first logged address of each byte slot. Host read data is sampled at the falling edge after the request edge. A flush or a host write is judged only by a later fetch's latency and bus traffic, or by a later host read.

// File: rtl/icache_reloc_pkg.sv
package icache_reloc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIT  = 2'd1,
        ST_FILL = 2'd2,
        ST_PASS = 2'd3
    } fst_e;

endpackage

// File: rtl/icache_reloc_seq.sv
module icache_reloc_seq
    import icache_reloc_pkg::*;
#(
    parameter int LINE_BYTES = 16,
    parameter int HIT_FAST   = 1,
    parameter int HIT_SLOW   = 2,
    parameter int MISS_FAST  = 5,
    parameter int MISS_SLOW  = 6,
    localparam int BYTE_W    = $clog2(LINE_BYTES),
    localparam int MAX_LAT   = (MISS_SLOW > MISS_FAST) ? MISS_SLOW : MISS_FAST,
    localparam int CYC_W     = $clog2(MAX_LAT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic              in_win,
    input  logic              line_hit,
    input  logic              fast,
    output fst_e              state,
    output logic              accept,
    output logic              ready,
    output logic              mem_req,
    output logic              fill_we,
    output logic              fill_done,
    output logic [BYTE_W-1:0] byte_idx
);

    logic [CYC_W-1:0] cyc;
    logic [CYC_W-1:0] lim;
    logic             fast_q;
    logic             step_done;

    // Length of the current slot, from the speed captured at acceptance
    always_comb begin
        if (state == ST_HIT)
            lim = fast_q ? CYC_W'(HIT_FAST - 1) : CYC_W'(HIT_SLOW - 1);
        else
            lim = fast_q ? CYC_W'(MISS_FAST - 1) : CYC_W'(MISS_SLOW - 1);
    end
    assign step_done = (cyc == lim);

    // State register with its slot and byte counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cyc      <= '0;
            byte_idx <= '0;
            fast_q   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (fetch_valid) begin
                        if (!in_win)       state <= ST_PASS;
                        else if (line_hit) state <= ST_HIT;
                        else               state <= ST_FILL;
                        cyc      <= '0;
                        byte_idx <= '0;
                        fast_q   <= fast;
                    end
                end
                default: begin
                    if (ready) begin
                        state <= ST_IDLE;
                    end else if (step_done) begin
                        cyc      <= '0;
                        byte_idx <= byte_idx + BYTE_W'(1);
                    end else begin
                        cyc <= cyc + CYC_W'(1);
                    end
                end
            endcase
        end
    end

    // Outputs decoded from the state
    always_comb begin
        accept    = 1'b0;
        ready     = 1'b0;
        mem_req   = 1'b0;
        fill_we   = 1'b0;
        fill_done = 1'b0;
        unique case (state)
            ST_IDLE: accept = fetch_valid;
            ST_HIT:  ready  = step_done;
            ST_FILL: begin
                mem_req   = 1'b1;
                fill_we   = step_done;
                fill_done = step_done && (byte_idx == BYTE_W'(LINE_BYTES - 1));
                ready     = fill_done;
            end
            ST_PASS: begin
                mem_req = 1'b1;
                ready   = step_done;
            end
        endcase
    end

endmodule

// File: rtl/icache_reloc_store.sv
module icache_reloc_store #(
    parameter int LINES      = 32,
    parameter int LINE_BYTES = 16,
    localparam int DEPTH     = LINES * LINE_BYTES,
    localparam int IDX_W     = $clog2(DEPTH),
    localparam int BYTE_W    = $clog2(LINE_BYTES),
    localparam int LINE_W    = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             fill_we,
    input  logic             fill_done,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [7:0]       fill_data,
    input  logic             host_we,
    input  logic [IDX_W-1:0] host_idx,
    input  logic [7:0]       host_wdata,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    output logic [7:0]       host_data,
    output logic [LINES-1:0] line_valid
);

    logic [7:0] bytes_q [DEPTH];
    logic       host_take;

    // A line fill owns the write port; a coinciding host write is dropped
    assign host_take = host_we && !fill_we;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) bytes_q[i] <= 8'h00;
        end else if (fill_we) begin
            bytes_q[fill_idx] <= fill_data;
        end else if (host_take) begin
            bytes_q[host_idx] <= host_wdata;
        end
    end

    assign rd_data   = bytes_q[rd_idx];
    assign host_data = bytes_q[host_idx];

    for (genvar l = 0; l < LINES; l++) begin : g_line
        logic set_fill;
        logic set_host;
        assign set_fill = fill_done && (fill_idx[IDX_W-1:BYTE_W] == LINE_W'(l));
        assign set_host = host_take && (host_idx[BYTE_W-1:0] == '1)
                          && (host_idx[IDX_W-1:BYTE_W] == LINE_W'(l));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    line_valid[l] <= 1'b0;
            else if (flush)                line_valid[l] <= 1'b0;
            else if (set_fill || set_host) line_valid[l] <= 1'b1;
        end
    end

endmodule

// File: rtl/icache_reloc.sv
module icache_reloc
    import icache_reloc_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int BANK_W     = 8,
    parameter int LINES      = 32,
    parameter int LINE_BYTES = 16,
    parameter int HIT_FAST   = 1,
    parameter int HIT_SLOW   = 2,
    parameter int MISS_FAST  = 5,
    parameter int MISS_SLOW  = 6,
    localparam int DEPTH     = LINES * LINE_BYTES,
    localparam int IDX_W     = $clog2(DEPTH),
    localparam int BYTE_W    = $clog2(LINE_BYTES),
    localparam int MEM_W     = BANK_W + ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [BANK_W-1:0] cfg_bank,
    input  logic              cfg_fast,
    input  logic              flush,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic              fetch_inc,
    output logic              fetch_ready,
    output logic [7:0]        fetch_rdata,
    output logic              mem_req,
    output logic [MEM_W-1:0]  mem_addr,
    input  logic [7:0]        mem_rdata,
    input  logic              host_en,
    input  logic              host_we,
    input  logic [IDX_W-1:0]  host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata
);

    fst_e                     state;
    logic                     accept, fill_we, fill_done;
    logic [BYTE_W-1:0]        byte_idx;
    logic [ADDR_W-1:0]        eff_addr, off_now;
    logic [ADDR_W-BYTE_W-1:0] src_now;
    logic                     in_win, line_hit, fwd;
    logic [LINES-1:0]         line_valid;
    logic [ADDR_W-1:0]        q_addr;
    logic [IDX_W-1:0]         q_idx, host_idx, fill_idx;
    logic [ADDR_W-BYTE_W-1:0] q_src;
    logic [BANK_W-1:0]        q_bank;
    logic [7:0]               rd_data, host_data, pipe_q;

    // Window arithmetic on the live request
    assign eff_addr = fetch_inc ? fetch_pc + ADDR_W'(1) : fetch_pc;
    assign off_now  = eff_addr - cfg_base;
    assign in_win   = off_now < ADDR_W'(DEPTH);
    assign line_hit = line_valid[off_now[IDX_W-1:BYTE_W]];
    // Aligned line source: base plus the line-aligned offset, low nibble dropped
    assign src_now  = cfg_base[ADDR_W-1:BYTE_W] + off_now[ADDR_W-1:BYTE_W];

    icache_reloc_seq #(
        .LINE_BYTES(LINE_BYTES), .HIT_FAST(HIT_FAST), .HIT_SLOW(HIT_SLOW),
        .MISS_FAST(MISS_FAST), .MISS_SLOW(MISS_SLOW)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .in_win(in_win),
        .line_hit(line_hit), .fast(cfg_fast), .state(state), .accept(accept),
        .ready(fetch_ready), .mem_req(mem_req), .fill_we(fill_we),
        .fill_done(fill_done), .byte_idx(byte_idx)
    );

    // Request capture at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_addr <= '0;
            q_idx  <= '0;
            q_src  <= '0;
            q_bank <= '0;
        end else if (accept) begin
            q_addr <= eff_addr;
            q_idx  <= off_now[IDX_W-1:0];
            q_src  <= src_now;
            q_bank <= cfg_bank;
        end
    end

    assign fill_idx = {q_idx[IDX_W-1:BYTE_W], byte_idx};
    assign host_idx = host_addr + cfg_base[IDX_W-1:0];
    assign mem_addr = (state == ST_FILL) ? {q_bank, q_src, byte_idx}
                                         : {q_bank, q_addr};

    icache_reloc_store #(.LINES(LINES), .LINE_BYTES(LINE_BYTES)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush), .fill_we(fill_we),
        .fill_done(fill_done), .fill_idx(fill_idx), .fill_data(mem_rdata),
        .host_we(host_en && host_we), .host_idx(host_idx),
        .host_wdata(host_wdata), .rd_idx(q_idx), .rd_data(rd_data),
        .host_data(host_data), .line_valid(line_valid)
    );

    // Bus byte goes to the prefetch register directly when it is not yet stored
    assign fwd = (state == ST_PASS)
              || (state == ST_FILL && q_idx[BYTE_W-1:0] == byte_idx);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q     <= 8'h00;
            host_rdata <= 8'h00;
        end else begin
            if (fetch_ready)           pipe_q     <= fwd ? mem_rdata : rd_data;
            if (host_en && !host_we)   host_rdata <= host_data;
        end
    end

    assign fetch_rdata = pipe_q;

endmodule

// File: rtl/icache_reloc_chk.sv
module icache_reloc_chk #(
    parameter int LINES = 32,
    parameter int MEM_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             fetch_ready,
    input logic [7:0]       fetch_rdata,
    input logic             mem_req,
    input logic [MEM_W-1:0] mem_addr,
    input logic [LINES-1:0] line_valid
);

    p_ready_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_ready |=> !fetch_ready);

    p_line_addr_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req)) |-> (mem_addr[MEM_W-1:4] == $past(mem_addr[MEM_W-1:4])));

    p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (line_valid == '0));

    p_pipe_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_ready |=> $stable(fetch_rdata));

endmodule

bind icache_reloc icache_reloc_chk #(.LINES(LINES), .MEM_W(MEM_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .fetch_ready(fetch_ready),
    .fetch_rdata(fetch_rdata), .mem_req(mem_req), .mem_addr(mem_addr),
    .line_valid(line_valid)
);

// File: tb/icache_reloc_tb.sv
module icache_reloc_tb;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_base = 16'h0;
    logic [7:0]  cfg_bank = 8'h0;
    logic        cfg_fast = 1'b0;
    logic        flush = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [15:0] fetch_pc = 16'h0;
    logic        fetch_inc = 1'b0;
    logic        fetch_ready;
    logic [7:0]  fetch_rdata;
    logic        mem_req;
    logic [23:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic        host_en = 1'b0;
    logic        host_we = 1'b0;
    logic [8:0]  host_addr = 9'h0;
    logic [7:0]  host_wdata = 8'h0;
    logic [7:0]  host_rdata;

    logic [7:0]  m_data [512];
    bit          m_valid [32];
    logic [7:0]  pipe_exp;
    int          nchk = 0;
    int          nerr = 0;

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [23:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ (a[23:16] + 8'h3C);
    endfunction

    assign mem_rdata = mem_byte(mem_addr);

    icache_reloc u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_bank(cfg_bank),
        .cfg_fast(cfg_fast), .flush(flush), .fetch_valid(fetch_valid),
        .fetch_pc(fetch_pc), .fetch_inc(fetch_inc), .fetch_ready(fetch_ready),
        .fetch_rdata(fetch_rdata), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .host_en(host_en), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; returns at a falling edge
    task automatic do_fetch(input logic [15:0] pc, input bit inc);
        logic [15:0] eff, off, lbase;
        logic [7:0]  exp_byte, old_b;
        logic [23:0] log_a [128];
        int kind, exp_lat, fl, n, nreq;
        eff = inc ? pc + 16'd1 : pc;
        off = eff - cfg_base;
        fl  = cfg_fast ? 5 : 6;
        lbase = 16'h0;
        if (off < 16'd512) begin
            if (m_valid[off[8:4]]) begin
                kind = 1; exp_lat = cfg_fast ? 1 : 2;
            end else begin
                kind = 2; exp_lat = 16 * fl;
                lbase = (cfg_base + (off & 16'hFFF0)) & 16'hFFF0;
                for (int k = 0; k < 16; k++)
                    m_data[{off[8:4], 4'(k)}] = mem_byte({cfg_bank, lbase[15:4], 4'(k)});
                m_valid[off[8:4]] = 1'b1;
            end
            exp_byte = m_data[off[8:0]];
        end else begin
            kind = 3; exp_lat = fl;
            exp_byte = mem_byte({cfg_bank, eff});
        end
        fetch_pc = pc; fetch_inc = inc; fetch_valid = 1'b1;
        @(posedge clk);
        n = 0; nreq = 0; old_b = 8'h0;
        while (n < 200) begin
            @(negedge clk);
            n++;
            if (mem_req) begin
                if (nreq < 128) log_a[nreq] = mem_addr;
                nreq++;
            end
            if (fetch_ready) begin
                old_b = fetch_rdata;
                break;
            end
        end
        @(posedge clk);
        @(negedge clk);
        fetch_valid = 1'b0;
        if (kind == 1) begin
            chk(n == exp_lat, "R5 R2 hit latency", n, exp_lat);
            chk(nreq == 0, "R5 hit bus cycles", nreq, 0);
        end else if (kind == 2) begin
            chk(n == exp_lat, "R4 R2 fill latency", n, exp_lat);
            chk(nreq == 16 * fl, "R3 fill bus cycles", nreq, 16 * fl);
            if (nreq == 16 * fl)
                for (int k = 0; k < 16; k++)
                    chk(log_a[k * fl] == {cfg_bank, lbase[15:4], 4'(k)}, "R3 fill address",
                        int'(log_a[k * fl]), int'({cfg_bank, lbase[15:4], 4'(k)}));
        end else begin
            chk(n == exp_lat, "R6 R2 bypass latency", n, exp_lat);
            chk(nreq == fl, "R6 bypass bus cycles", nreq, fl);
            if (nreq > 0)
                chk(log_a[0] == {cfg_bank, eff}, "R6 bypass address",
                    int'(log_a[0]), int'({cfg_bank, eff}));
        end
        chk(old_b == pipe_exp, "R10 held byte at handshake", int'(old_b), int'(pipe_exp));
        chk(fetch_rdata == exp_byte, "R10 prefetch byte", int'(fetch_rdata), int'(exp_byte));
        chk(fetch_ready == 1'b0, "R11 ready single cycle", int'(fetch_ready), 0);
        pipe_exp = exp_byte;
    endtask

    task automatic host_write(input logic [8:0] a, input logic [7:0] d);
        logic [8:0] idx;
        idx = a + cfg_base[8:0];
        host_en = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
        @(posedge clk);
        @(negedge clk);
        host_en = 1'b0; host_we = 1'b0;
        m_data[idx] = d;
        if (idx[3:0] == 4'hF) m_valid[idx[8:4]] = 1'b1;
    endtask

    task automatic host_read(input logic [8:0] a, input string tag);
        logic [8:0] idx;
        idx = a + cfg_base[8:0];
        host_en = 1'b1; host_we = 1'b0; host_addr = a;
        @(posedge clk);
        @(negedge clk);
        host_en = 1'b0;
        chk(host_rdata == m_data[idx], tag, int'(host_rdata), int'(m_data[idx]));
    endtask

    task automatic do_flush();
        flush = 1'b1;
        @(posedge clk);
        @(negedge clk);
        flush = 1'b0;
        for (int i = 0; i < 32; i++) m_valid[i] = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 512; i++) m_data[i] = 8'h00;
        for (int i = 0; i < 32; i++) m_valid[i] = 1'b0;
        pipe_exp = 8'h00;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(fetch_ready == 1'b0, "R1 ready after reset", int'(fetch_ready), 0);
        chk(mem_req == 1'b0, "R1 mem_req after reset", int'(mem_req), 0);
        chk(fetch_rdata == 8'h00, "R1 prefetch after reset", int'(fetch_rdata), 0);
        host_read(9'h000, "R1 data zero");
        host_read(9'h1FF, "R1 data zero");
        host_read(9'h0A7, "R1 data zero");

        cfg_base = 16'h1000; cfg_bank = 8'h12; cfg_fast = 1'b0;
        do_fetch(16'h1000, 1'b0);            // fill line 0, slow
        do_fetch(16'h1004, 1'b1);            // hit at 0x1005
        do_fetch(16'h11FF, 1'b0);            // offset 511, forwarded last byte
        do_fetch(16'h1200, 1'b0);            // offset 512: bypass (R2 edge)
        do_fetch(16'h0FFF, 1'b0);            // offset 0xFFFF: bypass
        host_read(9'h1FF, "R6 bypass left cache unchanged");
        cfg_fast = 1'b1;
        do_fetch(16'h1010, 1'b0);            // fast fill
        do_fetch(16'h1011, 1'b0);            // fast hit
        do_fetch(16'h3000, 1'b0);            // fast bypass
        host_read(9'h005, "R8 host read of filled byte");
        // R9: preload last byte of line 2
        host_write(9'h02E, 8'h3B);
        host_write(9'h02F, 8'hA5);
        do_fetch(16'h1023, 1'b0);            // R9 hit, data from reset value
        do_fetch(16'h102F, 1'b0);            // R9 hit with host byte
        host_write(9'h034, 8'h77);           // not last byte: line 3 stays invalid
        do_fetch(16'h1034, 1'b0);            // R9 fill expected
        // R7 flush keeps data, drops valid
        do_flush();
        host_read(9'h001, "R7 data kept after flush");
        do_fetch(16'h1001, 1'b0);            // R7 refill
        // Unaligned base
        cfg_base = 16'h2003;
        do_fetch(16'h2005, 1'b0);
        do_fetch(16'h2013, 1'b0);
        // Host index wrap
        cfg_base = 16'h0001;
        host_write(9'h1FF, 8'hC4);
        host_read(9'h1FF, "R8 host index wrap");
        // Window wrapping past 0xFFFF
        cfg_base = 16'hFFF8; cfg_fast = 1'b0;
        do_fetch(16'h0005, 1'b0);
        do_fetch(16'hFFF9, 1'b1);

        for (int it = 0; it < 220; it++) begin
            int op;
            op = int'($urandom % 100);
            if (op < 68) begin
                do_fetch(cfg_base + 16'($urandom % 600) - 16'd40, 1'($urandom % 2));
            end else if (op < 78) begin
                host_write(9'($urandom), 8'($urandom));
            end else if (op < 88) begin
                host_read(9'($urandom), "R8 random host read");
            end else if (op < 93) begin
                do_flush();
            end else begin
                case ($urandom % 4)
                    0: cfg_base = 16'h1000;
                    1: cfg_base = 16'h2003;
                    2: cfg_base = 16'hFFF8;
                    default: cfg_base = 16'($urandom);
                endcase
                cfg_bank = 8'($urandom);
                cfg_fast = 1'($urandom % 2);
            end
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule